// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit decides whether a conditional jump of a small 32-bit register machine is taken, and computes the program counter that follows it. Its inputs are:

- two register indices and the values read from them;
- a four-bit status-flag vector;
- a six-bit condition control field;
- a bit that selects an absolute or a PC-relative target;
- the current program counter, which points at the immediate word after the jump;
- that immediate word.

The unit first compares the two register values. It then picks one status flag. A two-bit mode merges the comparison result with the flag, and the result is the taken decision.

When the jump is taken, the next program counter is the immediate word. In relative mode the current program counter is added to it. When the jump is not taken, the program counter steps once, past the immediate word. The next program counter is captured in a register on a clock enable.

A second output gates a conditional register move. This gate uses only the selected flag. An enable bit turns the condition on, and another bit inverts its sense.

Top module: `branch_cond_unit`

## Requirements
- R1: Control bits 1:0 select the register comparison: 0 equal, 1 not equal, 2 unsigned less than, 3 unsigned less-or-equal (value A against value B).
- R2: With comparison 0, identical register indices make the comparison true whatever values are presented.
- R3: Control bits 3:2 select the tested flag from the flag vector: 0 overflow (bit 0), 1 zero (bit 1), 2 sign (bit 2), 3 parity (bit 3).
- R4: Control bits 5:4 merge comparison C and flag F into `taken`: 0 gives C, 1 gives C or F, 2 gives C and not F, 3 gives C or not F.
- R5: When taken with the relative select at 0, the registered next PC becomes the immediate word.
- R6: When taken with the relative select at 1, the registered next PC becomes the immediate word plus the current PC, modulo 2^32.
- R7: When not taken, the registered next PC becomes the current PC plus one, modulo 2^32.
- R8: The registered next PC loads only on a rising clock edge with the advance enable high, and holds otherwise.
- R9: A synchronous active-high reset sets the registered next PC to RESET_PC (default 0), overriding the advance enable.
- R10: The move gate is 1 when control bit 4 is 0. With bit 4 at 1 and bit 5 at 0, it is 1 exactly when the selected flag is 0. With bits 4 and 5 both at 1, it is 1 exactly when the selected flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance enable for the next-PC register |
| idx_a | input | 5 | Index of the first compared register |
| idx_b | input | 5 | Index of the second compared register |
| val_a | input | 32 | Value of the first compared register |
| val_b | input | 32 | Value of the second compared register |
| flags | input | 4 | Status flags: bit 0 overflow, bit 1 zero, bit 2 sign, bit 3 parity |
| ext | input | 6 | Condition control field |
| rel_sel | input | 1 | 1 selects a PC-relative target |
| pc_cur | input | 32 | Current PC, pointing at the immediate word |
| imm_word | input | 32 | Immediate target word |
| taken | output | 1 | Jump condition result |
| cmov_go | output | 1 | Conditional-move permit |
| pc_next_q | output | 32 | Registered next program counter |

## Verification
The checker watches the next-PC register on every cycle:

- it holds whenever the advance enable is low;
- it follows the absolute target or the increment when the enable is high;
- `taken` is forced by identical indices in plain-equality mode;
- the flag-only OR mode is honoured;
- the move gate stays open while its condition is disabled.

The full decode cannot be shown by properties. This covers every comparison against unsigned extremes, every flag and merge pairing, relative targets that wrap, and reset overriding the enable. Only the bench's sweep over all 64 control codes and 16 flag vectors shows these.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int FLAG_W = 4;
    localparam int CTL_W  = 6;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LTU = 2'd2,
        CMP_LEU = 2'd3
    } cmp_op_e;

    typedef enum logic [1:0] {
        FL_OVF  = 2'd0,
        FL_ZERO = 2'd1,
        FL_SIGN = 2'd2,
        FL_PAR  = 2'd3
    } flag_sel_e;

    typedef enum logic [1:0] {
        MIX_CMP  = 2'd0,
        MIX_OR   = 2'd1,
        MIX_ANDN = 2'd2,
        MIX_ORN  = 2'd3
    } mix_e;

    // Packed MSB first: mix in [5:4], flag select in [3:2], compare op in [1:0].
    typedef struct packed {
        mix_e      mix;
        flag_sel_e fsel;
        cmp_op_e   cop;
    } cond_ctl_t;

    function automatic logic mix_apply(input mix_e m, input logic c, input logic f);
        case (m)
            MIX_CMP:  return c;
            MIX_OR:   return c | f;
            MIX_ANDN: return c & ~f;
            default:  return c | ~f;
        endcase
    endfunction

endpackage

// File: rtl/bcu_compare.sv
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  cmp_op_e             cop,
    input  logic [IDX_W-1:0]    idx_a,
    input  logic [IDX_W-1:0]    idx_b,
    input  logic [DATA_W-1:0]   val_a,
    input  logic [DATA_W-1:0]   val_b,
    output logic                hit
);

    logic same_reg;
    logic eq_v;
    logic lt_v;

    assign same_reg = (idx_a == idx_b);
    assign eq_v     = (val_a == val_b);
    assign lt_v     = (val_a < val_b);

    always_comb begin
        case (cop)
            CMP_EQ:  hit = same_reg | eq_v;
            CMP_NE:  hit = ~eq_v;
            CMP_LTU: hit = lt_v;
            default: hit = lt_v | eq_v;
        endcase
    end

endmodule

// File: rtl/bcu_flag_eval.sv
module bcu_flag_eval
    import bcu_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  flag_sel_e         fsel,
    input  mix_e              mix,
    input  logic              cmp_hit,
    output logic              taken,
    output logic              cmov_go
);

    logic flag_bit;
    logic gate_en;
    logic gate_inv;

    assign flag_bit = flags[fsel];
    assign gate_en  = mix[0];
    assign gate_inv = mix[1];

    assign taken = mix_apply(mix, cmp_hit, flag_bit);

    always_comb begin
        if (!gate_en)
            cmov_go = 1'b1;
        else if (gate_inv)
            cmov_go = flag_bit;
        else
            cmov_go = ~flag_bit;
    end

endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic              taken,
    input  logic              rel_sel,
    input  logic [DATA_W-1:0] pc_cur,
    input  logic [DATA_W-1:0] imm_word,
    output logic [DATA_W-1:0] pc_q
);

    localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(1);
    localparam logic [DATA_W-1:0] PC_INIT = RESET_PC[DATA_W-1:0];

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] jump_tgt;
    logic [DATA_W-1:0] fall_tgt;
    logic [DATA_W-1:0] pc_d;

    assign base     = rel_sel ? pc_cur : '0;
    assign jump_tgt = imm_word + base;
    assign fall_tgt = pc_cur + PC_STEP;
    assign pc_d     = taken ? jump_tgt : fall_tgt;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= PC_INIT;
        else if (adv_en)
            pc_q <= pc_d;
    end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          IDX_W    = 5,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_b,
    input  logic [3:0]        flags,
    input  logic [5:0]        ext,
    input  logic              rel_sel,
    input  logic [DATA_W-1:0] pc_cur,
    input  logic [DATA_W-1:0] imm_word,
    output logic              taken,
    output logic              cmov_go,
    output logic [DATA_W-1:0] pc_next_q
);

    cond_ctl_t ctl;
    logic      cmp_hit;

    assign ctl = cond_ctl_t'(ext);

    bcu_compare #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
        .cop   (ctl.cop),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .val_a (val_a),
        .val_b (val_b),
        .hit   (cmp_hit)
    );

    bcu_flag_eval u_flag (
        .flags   (flags),
        .fsel    (ctl.fsel),
        .mix     (ctl.mix),
        .cmp_hit (cmp_hit),
        .taken   (taken),
        .cmov_go (cmov_go)
    );

    bcu_target #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_tgt (
        .clk      (clk),
        .rst      (rst),
        .adv_en   (adv_en),
        .taken    (taken),
        .rel_sel  (rel_sel),
        .pc_cur   (pc_cur),
        .imm_word (imm_word),
        .pc_q     (pc_next_q)
    );

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_en,
    input logic [IDX_W-1:0]  idx_a,
    input logic [IDX_W-1:0]  idx_b,
    input logic [3:0]        flags,
    input logic [5:0]        ext,
    input logic              rel_sel,
    input logic [DATA_W-1:0] pc_cur,
    input logic [DATA_W-1:0] imm_word,
    input logic              taken,
    input logic              cmov_go,
    input logic [DATA_W-1:0] pc_next_q
);

    assert_same_idx_eq_R2: assert property (@(posedge clk) disable iff (rst)
        (idx_a == idx_b && ext == 6'b000000) |-> taken);

    assert_or_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (ext[5:4] == 2'b01 && flags[ext[3:2]]) |-> taken);

    assert_abs_target_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_en && taken && !rel_sel) |=> (pc_next_q == $past(imm_word)));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !taken) |=> (pc_next_q == $past(pc_cur) + DATA_W'(1)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!adv_en) |=> $stable(pc_next_q));

    assert_gate_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!ext[4]) |-> cmov_go);

endmodule

bind branch_cond_unit bcu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_en    (adv_en),
    .idx_a     (idx_a),
    .idx_b     (idx_b),
    .flags     (flags),
    .ext       (ext),
    .rel_sel   (rel_sel),
    .pc_cur    (pc_cur),
    .imm_word  (imm_word),
    .taken     (taken),
    .cmov_go   (cmov_go),
    .pc_next_q (pc_next_q)
);

// File: tb/branch_cond_unit_bench.sv
module branch_cond_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [4:0]  idx_a = '0, idx_b = '0;
    logic [31:0] val_a = '0, val_b = '0;
    logic [3:0]  flags = '0;
    logic [5:0]  ext = '0;
    logic        rel_sel = 1'b0;
    logic [31:0] pc_cur = '0, imm_word = '0;
    logic        taken, cmov_go;
    logic [31:0] pc_next_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_cond_unit u_branch_cond_unit (
        .clk(clk), .rst(rst), .adv_en(adv_en),
        .idx_a(idx_a), .idx_b(idx_b), .val_a(val_a), .val_b(val_b),
        .flags(flags), .ext(ext), .rel_sel(rel_sel),
        .pc_cur(pc_cur), .imm_word(imm_word),
        .taken(taken), .cmov_go(cmov_go), .pc_next_q(pc_next_q)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model of R1..R4
    function automatic bit ref_taken(input logic [5:0] e, input logic [3:0] f,
                                     input logic [4:0] ia, input logic [4:0] ib,
                                     input logic [31:0] va, input logic [31:0] vb);
        bit c, fl;
        if (e[1:0] == 2'd0)      c = (ia == ib) || (va == vb);
        else if (e[1:0] == 2'd1) c = (va != vb);
        else if (e[1:0] == 2'd2) c = (va < vb);
        else                     c = (va <= vb);
        fl = f[e[3:2]];
        if (e[5:4] == 2'd0)      return c;
        else if (e[5:4] == 2'd1) return c || fl;
        else if (e[5:4] == 2'd2) return c && !fl;
        else                     return c || !fl;
    endfunction

    // Reference model of R10
    function automatic bit ref_cmov(input logic [5:0] e, input logic [3:0] f);
        bit fl;
        fl = f[e[3:2]];
        if (!e[4]) return 1'b1;
        return e[5] ? fl : !fl;
    endfunction

    initial begin
        #(2000000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc, held;
        bit et;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: state after reset
        check(pc_next_q == 32'h0, "R9 reset value", pc_next_q, 32'h0);
        rst = 1'b0;
        adv_en = 1'b1;

        // Sweep R1 R2 R3 R4 R5 R6 R7 R10
        for (int e = 0; e < 64; e++) begin
            for (int f = 0; f < 16; f++) begin
                for (int p = 0; p < 5; p++) begin
                    for (int r = 0; r < 2; r++) begin
                        @(negedge clk);
                        ext = 6'(e);
                        flags = 4'(f);
                        rel_sel = r[0];
                        idx_a = 5'd3;
                        idx_b = 5'd7;
                        case (p)
                            0: begin val_a = 32'd5; val_b = 32'd9; end
                            1: begin val_a = 32'd9; val_b = 32'd5; end
                            2: begin val_a = 32'd7; val_b = 32'd7; end
                            3: begin val_a = 32'hFFFF_FFFF; val_b = 32'd1; end
                            default: begin idx_b = 5'd3; val_a = 32'd3; val_b = 32'd8; end
                        endcase
                        pc_cur = (p == 3) ? 32'hFFFF_FFFF : 32'h1000 + 32'(e * 16 + f);
                        imm_word = (p == 1) ? 32'hFFFF_FFF0 : 32'h40 + 32'(p);
                        #1;
                        et = ref_taken(ext, flags, idx_a, idx_b, val_a, val_b);
                        check(taken == et, "R1 R2 R3 R4 taken", 32'(taken), 32'(et));
                        check(cmov_go == ref_cmov(ext, flags), "R10 move gate",
                              32'(cmov_go), 32'(ref_cmov(ext, flags)));
                        if (!et)          exp_pc = pc_cur + 32'd1;
                        else if (rel_sel) exp_pc = imm_word + pc_cur;
                        else              exp_pc = imm_word;
                        @(posedge clk);
                        #1;
                        check(pc_next_q == exp_pc,
                              !et ? "R7 fall-through" : (rel_sel ? "R6 relative" : "R5 absolute"),
                              pc_next_q, exp_pc);
                    end
                end
            end
        end

        // R8: enable low holds the register while inputs change
        @(negedge clk);
        held = pc_next_q;
        adv_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ext = 6'(k * 13);
            pc_cur = 32'h2222_0000 + 32'(k);
            imm_word = 32'h3333_0000 + 32'(k);
            @(posedge clk);
            #1;
            check(pc_next_q == held, "R8 hold", pc_next_q, held);
        end

        // R9: reset wins over enable
        @(negedge clk);
        adv_en = 1'b1;
        rst = 1'b1;
        ext = 6'd0;
        rel_sel = 1'b0;
        imm_word = 32'h5555_5555;
        @(posedge clk);
        #1;
        check(pc_next_q == 32'h0, "R9 reset over enable", pc_next_q, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule